// File: doc/BRIEF.md
# Multi-Channel Serial Word Collector

The block gathers serial bit streams from up to six synchronised sources. All sources share one time base. Each source presents a data bit, a bit strobe and a frame-start flag. Each source has its own lane. The lane shifts bits into 24-bit words, most significant bit first. A frame holds a parameterised number of data words followed by one check word. The lane accumulates the bitwise XOR of the frame's data words and compares that result with the check word.

Each lane holds one completed word in a single holding slot. A round-robin arbiter picks among the lanes that have a full slot. The word, its source index and its flags are then offered to a host memory write port. The port uses a request/acknowledge handshake and the write address comes from a local counter. After each accepted word a one-cycle done pulse is raised. Frame data is never held back because of a parity mismatch. The frame's check word is delivered with an error mark set beside it instead. A lane that completes a word while its slot is still occupied drops the new word and sets a sticky overrun bit.

A run is started with a one-cycle `run_start` pulse. The pulse zeroes the address counter and the overrun bits. Transfers begin only while `host_link` reports that the host side is connected.

Top module: `smux_top`

## Requirements
- R1: After reset, `mem_req`, `mem_done` and every `overrun` bit are 0 and `mem_addr` is 0.
- R2: Serial bits are assembled most significant bit first: the bit strobed together with the frame-start flag ends up in `mem_data[23]`.
- R3: A frame of FRAME_DATA data words (default 3) is followed by one check word. Data words are delivered in arrival order with `mem_chk`=0 and `mem_err`=0. The check word is delivered last with `mem_chk`=1. Its `mem_err` is 0 when it equals the XOR of the frame's data words.
- R4: When the check word differs from the XOR of the frame's data words, all words are still delivered and the check word carries `mem_err`=1.
- R5: While `host_link` is 0, no new request is raised. Completed words wait in their lanes and are delivered once `host_link` returns to 1.
- R6: Once raised, `mem_req` stays high with `mem_data`, `mem_addr`, `mem_src`, `mem_chk` and `mem_err` unchanged until `mem_ack` is seen. In the cycle after the acknowledging edge, `mem_done` is 1 for exactly one cycle and `mem_req` is 0.
- R7: `mem_addr` starts at 0 after reset or `run_start` and grows by one for every acknowledged word.
- R8: When several lanes hold words, they are served in round-robin order starting with the lane after the one served last. After reset, lane 0 comes first.
- R9: A lane that completes a word while its slot is still occupied discards the new word and sets its sticky `overrun` bit. Only `run_start` clears that bit.
- R10: Strobes received outside a frame (before any frame start, or after the check word) are ignored. Only a strobe with the frame-start flag begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | One-cycle pulse: zero address counter and overrun bits |
| host_link | input | 1 | Host side connected; transfers permitted |
| ser_bit | input | N_CH | Serial data bit per lane |
| ser_stb | input | N_CH | Bit strobe per lane |
| ser_frm | input | N_CH | Frame start per lane, valid with the first bit's strobe |
| mem_req | output | 1 | Write request to host memory |
| mem_ack | input | 1 | Host accepts the offered word |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | 24 | Word being written |
| mem_chk | output | 1 | Offered word is a frame check word |
| mem_err | output | 1 | Parity mismatch mark for the offered check word |
| mem_src | output | CH_W | Lane index of the offered word |
| mem_done | output | 1 | One-cycle pulse after each completed transfer |
| overrun | output | N_CH | Sticky per-lane overrun bits |

## Verification
Some properties are checked on every cycle: the handshake holds the request and its payload stable until acknowledge, every completion yields a single done pulse with the address advanced by one, no request starts while the link is down, and overrun bits never fall without a run start. The parity verdict, the bit order, the order of words within a frame, the round-robin order and the discarding of an overrunning word all depend on the serial content. Only the bench's scenarios show these, by comparing every delivered word against what it sent on each lane.

// File: rtl/smux_pkg.sv
// Shared definitions for the serial word collector.
// Assumes a fixed 24-bit word; every other size is a module parameter.
package smux_pkg;
    localparam int WORD_W = 24;

    // One completed word waiting in a lane.
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              chk;
        logic              err;
    } slot_t;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_BUSY = 1'b1
    } xfer_state_t;
endpackage

// File: rtl/smux_lane.sv
// Per-lane assembler: shifts serial bits into words (MSB first), tracks the
// position within a frame, accumulates the XOR of data words and judges the
// trailing check word. Holds one completed word until the arbiter consumes it.
// Assumes the frame-start flag arrives with the strobe of the frame's first bit.
module smux_lane
    import smux_pkg::*;
#(
    parameter int FRAME_DATA = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  s_bit,
    input  logic  s_stb,
    input  logic  s_frm,
    input  logic  clr,
    input  logic  ovr_clr,
    output slot_t slot,
    output logic  full,
    output logic  ovr
);
    localparam int BCNT_W = $clog2(WORD_W);
    localparam int IDX_W  = $clog2(FRAME_DATA + 1);

    logic [WORD_W-1:0] shreg, nxt_shift, acc;
    logic [BCNT_W-1:0] bcnt;
    logic [IDX_W-1:0]  widx;
    logic              in_frame, take, word_done, is_chk;

    // Next shift value, and whether this strobe completes a word.
    always_comb begin
        nxt_shift = {shreg[WORD_W-2:0], s_bit};
        take      = s_stb && (s_frm || in_frame);
        word_done = take && !s_frm && (bcnt == BCNT_W'(WORD_W - 1));
        is_chk    = (widx == IDX_W'(FRAME_DATA));
    end

    // Bit and word position tracking plus parity accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bcnt     <= '0;
            widx     <= '0;
            acc      <= '0;
            in_frame <= 1'b0;
        end else if (take) begin
            shreg <= nxt_shift;
            if (s_frm) begin
                in_frame <= 1'b1;
                bcnt     <= BCNT_W'(1);
                widx     <= '0;
                acc      <= '0;
            end else if (word_done) begin
                bcnt <= '0;
                if (is_chk) begin
                    in_frame <= 1'b0;
                end else begin
                    acc  <= acc ^ nxt_shift;
                    widx <= widx + IDX_W'(1);
                end
            end else begin
                bcnt <= bcnt + BCNT_W'(1);
            end
        end
    end

    // Holding slot: load when free or being freed, otherwise drop the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            full <= 1'b0;
        end else if (word_done && (!full || clr)) begin
            slot.data <= nxt_shift;
            slot.chk  <= is_chk;
            slot.err  <= is_chk && (acc != nxt_shift);
            full      <= 1'b1;
        end else if (clr) begin
            full <= 1'b0;
        end
    end

    // Sticky overrun flag, cleared only at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n || ovr_clr) begin
            ovr <= 1'b0;
        end else if (word_done && full && !clr) begin
            ovr <= 1'b1;
        end
    end
endmodule

// File: rtl/smux_rr.sv
// Round-robin picker: among requesting lanes, grants the first one found
// after the lane served last, wrapping around. Purely combinational.
module smux_rr #(
    parameter int N_CH = 6,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] req,
    input  logic [CH_W-1:0] last,
    output logic [CH_W-1:0] gnt,
    output logic            any
);
    // Scan from the farthest offset down so the nearest requester wins.
    always_comb begin
        gnt = '0;
        any = 1'b0;
        for (int off = N_CH; off >= 1; off--) begin
            if (req[(int'(last) + off) % N_CH]) begin
                gnt = CH_W'((int'(last) + off) % N_CH);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/smux_top.sv
// Serial word collector top: N_CH lanes, a round-robin arbiter and a
// request/acknowledge write controller with an address counter and done pulse.
// Assumes the host holds mem_ack for one cycle per accepted word and that
// run_start is only pulsed while no transfer is in flight.
module smux_top
    import smux_pkg::*;
#(
    parameter int N_CH       = 6,
    parameter int FRAME_DATA = 3,
    parameter int ADDR_W     = 12,
    localparam int CH_W      = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_start,
    input  logic              host_link,
    input  logic [N_CH-1:0]   ser_bit,
    input  logic [N_CH-1:0]   ser_stb,
    input  logic [N_CH-1:0]   ser_frm,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              mem_chk,
    output logic              mem_err,
    output logic [CH_W-1:0]   mem_src,
    output logic              mem_done,
    output logic [N_CH-1:0]   overrun
);
    slot_t           lane_slot [N_CH];
    logic [N_CH-1:0] lane_full, lane_clr;
    logic [CH_W-1:0] last_q, gnt;
    logic            gnt_any;
    xfer_state_t     state;

    for (genvar i = 0; i < N_CH; i++) begin : g_lane
        // Free the slot of the lane whose word is being acknowledged.
        assign lane_clr[i] = (state == XS_BUSY) && mem_ack && (mem_src == CH_W'(i));

        smux_lane #(.FRAME_DATA(FRAME_DATA)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_bit   (ser_bit[i]),
            .s_stb   (ser_stb[i]),
            .s_frm   (ser_frm[i]),
            .clr     (lane_clr[i]),
            .ovr_clr (run_start),
            .slot    (lane_slot[i]),
            .full    (lane_full[i]),
            .ovr     (overrun[i])
        );
    end

    smux_rr #(.N_CH(N_CH)) u_rr (
        .req  (lane_full),
        .last (last_q),
        .gnt  (gnt),
        .any  (gnt_any)
    );

    // Transfer sequencing: offer a granted word, wait for ack, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= XS_IDLE;
            mem_req  <= 1'b0;
            mem_done <= 1'b0;
            mem_data <= '0;
            mem_chk  <= 1'b0;
            mem_err  <= 1'b0;
            mem_src  <= '0;
            last_q   <= CH_W'(N_CH - 1);
        end else begin
            mem_done <= 1'b0;
            case (state)
                XS_IDLE: begin
                    if (host_link && gnt_any) begin
                        mem_req  <= 1'b1;
                        mem_data <= lane_slot[gnt].data;
                        mem_chk  <= lane_slot[gnt].chk;
                        mem_err  <= lane_slot[gnt].err;
                        mem_src  <= gnt;
                        last_q   <= gnt;
                        state    <= XS_BUSY;
                    end
                end
                XS_BUSY: begin
                    if (mem_ack) begin
                        mem_req  <= 1'b0;
                        mem_done <= 1'b1;
                        state    <= XS_IDLE;
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    // Write address counter: zeroed at run start, advanced per delivered word.
    always_ff @(posedge clk) begin
        if (!rst_n || run_start) begin
            mem_addr <= '0;
        end else if (state == XS_BUSY && mem_ack) begin
            mem_addr <= mem_addr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/smux_chk.sv
// Protocol checker for smux_top, attached with bind. Observes ports only.
module smux_chk
    import smux_pkg::*;
#(
    parameter int N_CH   = 6,
    parameter int ADDR_W = 12,
    localparam int CH_W  = $clog2(N_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_start,
    input logic              host_link,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_data,
    input logic              mem_chk,
    input logic              mem_err,
    input logic [CH_W-1:0]   mem_src,
    input logic              mem_done,
    input logic [N_CH-1:0]   overrun
);
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_data) && $stable(mem_src)
                                && $stable(mem_chk) && $stable(mem_err) && $stable(mem_addr));

    // R6
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> mem_done && !mem_req);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |=> !mem_done);

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !run_start |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R5
    link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_link && !mem_req |=> !mem_req);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_start |=> (overrun & $past(overrun)) == $past(overrun));
endmodule

bind smux_top smux_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/smux_top_tb.sv
// Scoreboard bench: driver tasks push expected words per lane, a host-side
// monitor acknowledges requests and compares what the design delivers.
module smux_top_tb;
    localparam int N_CH = 6;
    localparam int FD   = 3;
    localparam int AW   = 12;
    localparam int CW   = $clog2(N_CH);

    typedef struct {
        logic [23:0] data;
        logic        chk;
        logic        err;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_start = 1'b0;
    logic host_link = 1'b0;
    logic [N_CH-1:0] sb = '0, ss = '0, sf = '0;
    logic mem_req, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [23:0] mem_data;
    logic mem_chk, mem_err, mem_done;
    logic [CW-1:0] mem_src;
    logic [N_CH-1:0] overrun;

    int checks = 0;
    int failures = 0;
    int exp_addr = 0;
    int cycles = 0;
    exp_t exp_q [N_CH][$];
    int served_q [$];

    always #4 clk = ~clk;

    smux_top #(.N_CH(N_CH), .FRAME_DATA(FD), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .host_link(host_link),
        .ser_bit(sb), .ser_stb(ss), .ser_frm(sf),
        .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_chk(mem_chk), .mem_err(mem_err),
        .mem_src(mem_src), .mem_done(mem_done), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic push(input int ch, input logic [23:0] d, input logic c, input logic e);
        exp_t it;
        it.data = d; it.chk = c; it.err = e;
        exp_q[ch].push_back(it);
    endtask

    // Send one 24-bit word on a lane, MSB first, one strobe every two cycles.
    task automatic send_word(input int ch, input logic [23:0] w, input bit first);
        for (int b = 23; b >= 0; b--) begin
            @(negedge clk);
            sb[ch] = w[b];
            ss[ch] = 1'b1;
            sf[ch] = first && (b == 23);
            @(negedge clk);
            ss[ch] = 1'b0;
            sf[ch] = 1'b0;
        end
    endtask

    function automatic logic [23:0] pat(input int ch, input int seed, input int k);
        return {8'(ch * 16 + k), 16'(seed * 977 + k * 4099 + 16'h5a3c)};
    endfunction

    // Full frame; push_all=0 expects only the first word (rest overrun).
    task automatic send_frame(input int ch, input int seed, input bit bad, input bit push_all);
        logic [23:0] x = '0;
        for (int k = 0; k < FD; k++) x ^= pat(ch, seed, k);
        if (bad) x ^= 24'h000100;
        for (int k = 0; k < FD; k++)
            if (push_all || k == 0) push(ch, pat(ch, seed, k), 1'b0, 1'b0);
        if (push_all) push(ch, x, 1'b1, bad);
        for (int k = 0; k < FD; k++) send_word(ch, pat(ch, seed, k), k == 0);
        send_word(ch, x, 1'b0);
    endtask

    // Frame start plus exactly one data word.
    task automatic send_partial(input int ch, input logic [23:0] w);
        push(ch, w, 1'b0, 1'b0);
        send_word(ch, w, 1'b1);
    endtask

    function automatic bit all_empty();
        for (int c = 0; c < N_CH; c++) if (exp_q[c].size() != 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic drain();
        int n = 0;
        while ((!all_empty() || mem_req) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_run();
        @(negedge clk);
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
        exp_addr = 0;
    endtask

    // Host-side monitor: acknowledge with 0..2 cycles delay and compare.
    initial begin : monitor
        int dly = 0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                repeat (dly) @(negedge clk);
                dly = (dly + 1) % 3;
                served_q.push_back(int'(mem_src));
                check(mem_addr == AW'(exp_addr), "R7", "address", 32'(mem_addr), 32'(exp_addr));
                if (exp_q[mem_src].size() == 0) begin
                    check(1'b0, "R3", "unexpected word", 32'(mem_data), 32'(mem_src));
                end else begin
                    exp_t e;
                    e = exp_q[mem_src].pop_front();
                    check(mem_data == e.data, "R3", "data", 32'(mem_data), 32'(e.data));
                    check(mem_chk == e.chk, "R3", "check-word flag", 32'(mem_chk), 32'(e.chk));
                    check(mem_err == e.err, "R4", "parity mark", 32'(mem_err), 32'(e.err));
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                exp_addr++;
                check(mem_done && !mem_req, "R6", "done pulse after ack",
                      32'({mem_done, mem_req}), 32'h2);
            end
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "WATCHDOG", "run did not end", 32'(cycles), 32'd150000);
                finish_run();
            end
        end
    end

    initial begin : stimulus
        int base;
        int cur;
        int order [3];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!mem_req && !mem_done, "R1", "req/done after reset", 32'({mem_req, mem_done}), 32'h0);
        check(overrun == '0, "R1", "overrun after reset", 32'(overrun), 32'h0);
        check(mem_addr == '0, "R1", "address after reset", 32'(mem_addr), 32'h0);

        // R10: strobes before any frame start are ignored
        host_link = 1'b1;
        send_word(0, 24'hFFFFFF, 1'b0);
        repeat (10) @(negedge clk);
        check(served_q.size() == 0 && !mem_req, "R10", "stray bits before frame",
              32'(served_q.size()), 32'h0);

        // R2: MSB first, single partial word on lane 0
        send_partial(0, 24'h800001);
        drain();
        check(served_q.size() == 1, "R2", "msb-first word delivered", 32'(served_q.size()), 32'h1);

        // R3: good frame on lane 0; R4: bad parity frame on lane 3
        send_frame(0, 1, 1'b0, 1'b1);
        drain();
        send_frame(3, 2, 1'b1, 1'b1);
        drain();

        // R10: stray strobes after a finished frame are ignored
        base = served_q.size();
        send_word(3, 24'h123456, 1'b0);
        repeat (10) @(negedge clk);
        check(served_q.size() == base && !mem_req, "R10", "stray bits after frame",
              32'(served_q.size() - base), 32'h0);

        // R5: link down holds the word back
        host_link = 1'b0;
        send_partial(2, 24'h0F0F0F);
        repeat (100) @(negedge clk);
        check(!mem_req, "R5", "no request while link down", 32'(mem_req), 32'h0);
        check(exp_q[2].size() == 1, "R5", "word still pending", 32'(exp_q[2].size()), 32'h1);
        host_link = 1'b1;
        drain();
        check(exp_q[2].size() == 0, "R5", "word delivered after link up", 32'(exp_q[2].size()), 32'h0);

        // R3/R4: all lanes concurrently, mixed parity
        for (int c = 0; c < N_CH; c++) begin
            automatic int cc = c;
            fork
                send_frame(cc, 10 + cc, (cc % 2) == 1, 1'b1);
            join_none
        end
        wait fork;
        drain();
        check(overrun == '0, "R9", "no overrun with fast host", 32'(overrun), 32'h0);

        // R9: overrun while link down; only the first word survives
        host_link = 1'b0;
        send_frame(2, 40, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check(overrun == 6'b000100, "R9", "overrun bit set", 32'(overrun), 32'h4);
        host_link = 1'b1;
        drain();
        check(overrun == 6'b000100, "R9", "overrun sticky after drain", 32'(overrun), 32'h4);
        pulse_run();
        check(overrun == '0, "R9", "overrun cleared by run start", 32'(overrun), 32'h0);
        check(mem_addr == '0, "R7", "address zeroed by run start", 32'(mem_addr), 32'h0);

        // R8: round robin among lanes 1, 4, 5 waiting together
        cur = served_q[served_q.size() - 1];
        for (int k = 0; k < 3; k++) begin
            for (int off = 1; off <= N_CH; off++) begin
                automatic int cand = (cur + off) % N_CH;
                if (cand == 1 || cand == 4 || cand == 5) begin
                    bit used = 1'b0;
                    for (int j = 0; j < k; j++) if (order[j] == cand) used = 1'b1;
                    if (!used) begin
                        order[k] = cand;
                        cur = cand;
                        break;
                    end
                end
            end
        end
        host_link = 1'b0;
        base = served_q.size();
        fork
            send_partial(1, 24'hA00001);
            send_partial(4, 24'hA00004);
            send_partial(5, 24'hA00005);
        join
        repeat (6) @(negedge clk);
        host_link = 1'b1;
        drain();
        for (int k = 0; k < 3; k++)
            check(served_q.size() > base + k && served_q[base + k] == order[k], "R8",
                  "round-robin order", 32'(served_q.size() > base + k ? served_q[base + k] : -1),
                  32'(order[k]));

        check(all_empty(), "R3", "all expected words delivered", 32'(all_empty()), 32'h1);
        finish_run();
    end
endmodule